// File: doc/BRIEF.md
# Processor Power Mode Controller

This block chooses the power mode of a processor core from bits that software writes into a control word. It covers five modes. Full power can run with dynamic power management off or on. The three low-power modes are doze, nap and sleep. The block drives clock enables for a group of functional units, the data cache, the snoop logic and the timer. It also reports the current mode as a 3-bit code.

Doze starts after a short fixed delay. While the core dozes, a bus-snoop hit briefly turns the cache path back on so that one line can be copied back to memory, and then the core returns to doze. Nap and sleep need agreement from the peripheral logic. The block raises a quiesce request and moves into the low-power mode only once the acknowledge arrives. When that acknowledge later drops, the core wakes to full power. The copy-back itself is modelled as a request and done pair.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode code is 0 (full power, management off). In that mode every unit clock enable is high, the cache, snoop and timer enables are high, and neither quiesce_req nor copyback_req is asserted.
- R2: Bit 11 of pm_ctrl turns on dynamic management. While the core is at full power with that bit set, the mode code is 1 and each unit_clk_en bit equals its unit_req bit in the same cycle. The cache, snoop and timer enables stay high.
- R3: Bit 8 of pm_ctrl asks for doze. Take the first rising edge at which doze is the selected request. The mode code reads 2 after the fourth rising edge that follows it. Until then the mode code shows full power.
- R4: In doze (code 2) all unit enables and the cache enable are low, and the snoop and timer enables are high.
- R5: A snoop_hit sampled in doze starts the snoop service (code 5), which runs in this order. First, one cycle with the cache enable on. Next, copyback_req and the cache enable both high until copyback_done is sampled. Then one cycle with the cache enable off. After that the block is back in doze. The snoop and timer enables stay high throughout.
- R6: Bit 9 asks for nap and bit 10 asks for sleep. After such a request the block asserts quiesce_req. It enters nap (code 3) or sleep (code 4) only on an edge at which quiesce_ack is high.
- R7: In nap or sleep, an edge that samples quiesce_ack low returns the block to full power (code 0 or 1, chosen by bit 11), and quiesce_req drops in the same cycle.
- R8: When several low-power bits are set, sleep takes precedence over nap, and nap takes precedence over doze.
- R9: quiesce_req is high while the block waits for the acknowledge and for the whole time it is in nap or sleep. If the nap and sleep bits are cleared before the acknowledge arrives, the block returns to full power and drops quiesce_req.
- R10: Nap keeps the timer enable high. Sleep drives it low. In both modes the unit, cache and snoop enables are low.
- R11: The mode codes are 0 for full power, 1 for full power with management, 2 for doze, 3 for nap, 4 for sleep and 5 for snoop service. No other code ever appears.
- R12: If doze is no longer selected while the block is in doze, the block returns to full power on the next edge. If this happens during snoop service, the service sequence finishes first and only then does the block leave doze.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pm_ctrl | input | CTRL_W (32) | Software control word: bit 11 management, bit 8 doze, bit 9 nap, bit 10 sleep |
| unit_req | input | N_UNITS (4) | Activity request for each functional-unit group |
| quiesce_ack | input | 1 | Acknowledge from the peripheral logic |
| snoop_hit | input | 1 | Snoop hit that needs a copy-back |
| copyback_done | input | 1 | Copy-back has completed |
| unit_clk_en | output | N_UNITS (4) | Clock enable for each functional-unit group |
| cache_clk_en | output | 1 | Data cache clock enable |
| snoop_clk_en | output | 1 | Snoop logic clock enable |
| timer_clk_en | output | 1 | Timer clock enable |
| copyback_req | output | 1 | Request to copy back the snooped line |
| quiesce_req | output | 1 | Request for the peripheral logic to quiesce |
| mode | output | 3 | Current mode code |

## Verification
The assertions assume that the control word, the acknowledge, the snoop hit and the copy-back done inputs are synchronous to clk. They also assume that copyback_done matters only while a copy-back is being requested. Under that assumption, any wake or entry into nap or sleep can be traced to the acknowledge value sampled on the previous edge. The stimulus changes every input one nanosecond after a rising edge and compares outputs on the falling edge. Its directed part holds the acknowledge steady across entry and wake. Its randomized part toggles the acknowledge and the done pulse freely, but it changes the mode bits only every sixteen cycles, so each low-power path can be reached.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    typedef enum logic [2:0] {
        MODE_FULL  = 3'd0,
        MODE_DPM   = 3'd1,
        MODE_DOZE  = 3'd2,
        MODE_NAP   = 3'd3,
        MODE_SLEEP = 3'd4,
        MODE_SNOOP = 3'd5
    } pwr_mode_e;

    typedef enum logic [3:0] {
        ST_RUN,
        ST_DOZE_WAIT,
        ST_QUIESCE,
        ST_NAP,
        ST_SLEEP,
        ST_DOZE,
        ST_SN_OPEN,
        ST_SN_FLUSH,
        ST_SN_CLOSE
    } seq_state_e;

    typedef enum logic [1:0] {
        LP_NONE,
        LP_DOZE,
        LP_NAP,
        LP_SLEEP
    } lp_req_e;

    typedef struct packed {
        logic    dpm;
        lp_req_e lp;
    } ctrl_dec_t;

    typedef struct packed {
        logic cache;
        logic snoop;
        logic timer;
        logic cb_req;
        logic qreq;
    } gate_t;

    // Sleep outranks nap, nap outranks doze.
    function automatic lp_req_e pick_lp(input logic sleep_b, input logic nap_b, input logic doze_b);
        if (sleep_b)     return LP_SLEEP;
        else if (nap_b)  return LP_NAP;
        else if (doze_b) return LP_DOZE;
        else             return LP_NONE;
    endfunction

    function automatic logic is_quiet_req(input lp_req_e lp);
        return (lp == LP_NAP) || (lp == LP_SLEEP);
    endfunction

endpackage

// File: rtl/pwr_ctrl_decode.sv
module pwr_ctrl_decode
    import pwr_pkg::*;
#(
    parameter int CTRL_W    = 32,
    parameter int DPM_BIT   = 11,
    parameter int DOZE_BIT  = 8,
    parameter int NAP_BIT   = 9,
    parameter int SLEEP_BIT = 10
) (
    input  logic [CTRL_W-1:0] ctrl,
    output ctrl_dec_t         dec
);
    logic ctrl_unused;
    assign ctrl_unused = ^ctrl;

    always_comb begin
        dec.dpm = ctrl[DPM_BIT];
        dec.lp  = pick_lp(ctrl[SLEEP_BIT], ctrl[NAP_BIT], ctrl[DOZE_BIT]);
    end
endmodule

// File: rtl/pwr_doze_delay.sv
module pwr_doze_delay #(
    parameter int DLY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic count_en,
    output logic expired
);
    localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !count_en) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign expired = count_en && (cnt == CW'(DLY - 1));
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ctrl_dec_t  dec,
    input  logic       qack,
    input  logic       snoop_hit,
    input  logic       cb_done,
    input  logic       doze_expired,
    output seq_state_e state
);
    seq_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (is_quiet_req(dec.lp))    nxt = ST_QUIESCE;
                else if (dec.lp == LP_DOZE)  nxt = ST_DOZE_WAIT;
            end
            ST_DOZE_WAIT: begin
                if (dec.lp != LP_DOZE)       nxt = ST_RUN;
                else if (doze_expired)       nxt = ST_DOZE;
            end
            ST_QUIESCE: begin
                if (!is_quiet_req(dec.lp))   nxt = ST_RUN;
                else if (qack)               nxt = (dec.lp == LP_SLEEP) ? ST_SLEEP : ST_NAP;
            end
            ST_NAP, ST_SLEEP: begin
                if (!qack)                   nxt = ST_RUN;
            end
            ST_DOZE: begin
                if (snoop_hit)               nxt = ST_SN_OPEN;
                else if (dec.lp != LP_DOZE)  nxt = ST_RUN;
            end
            ST_SN_OPEN:                      nxt = ST_SN_FLUSH;
            ST_SN_FLUSH: begin
                if (cb_done)                 nxt = ST_SN_CLOSE;
            end
            ST_SN_CLOSE:                     nxt = ST_DOZE;
            default:                         nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= nxt;
    end
endmodule

// File: rtl/pwr_gate_decode.sv
module pwr_gate_decode
    import pwr_pkg::*;
#(
    parameter int N_UNITS = 4
) (
    input  seq_state_e         state,
    input  logic               dpm,
    input  logic [N_UNITS-1:0] unit_req,
    output logic [N_UNITS-1:0] unit_en,
    output gate_t              gate,
    output pwr_mode_e          mode
);
    logic full_pwr;

    assign full_pwr = (state == ST_RUN) || (state == ST_DOZE_WAIT) || (state == ST_QUIESCE);

    genvar u;
    generate
        for (u = 0; u < N_UNITS; u++) begin : g_unit
            assign unit_en[u] = full_pwr && (!dpm || unit_req[u]);
        end
    endgenerate

    always_comb begin
        gate = '{cache: 1'b0, snoop: 1'b1, timer: 1'b1, cb_req: 1'b0, qreq: 1'b0};
        mode = dpm ? MODE_DPM : MODE_FULL;
        unique case (state)
            ST_RUN, ST_DOZE_WAIT: gate.cache = 1'b1;
            ST_QUIESCE: begin
                gate.cache = 1'b1;
                gate.qreq  = 1'b1;
            end
            ST_NAP: begin
                gate.snoop = 1'b0;
                gate.qreq  = 1'b1;
                mode       = MODE_NAP;
            end
            ST_SLEEP: begin
                gate.snoop = 1'b0;
                gate.timer = 1'b0;
                gate.qreq  = 1'b1;
                mode       = MODE_SLEEP;
            end
            ST_DOZE: mode = MODE_DOZE;
            ST_SN_OPEN: begin
                gate.cache = 1'b1;
                mode       = MODE_SNOOP;
            end
            ST_SN_FLUSH: begin
                gate.cache  = 1'b1;
                gate.cb_req = 1'b1;
                mode        = MODE_SNOOP;
            end
            ST_SN_CLOSE: mode = MODE_SNOOP;
            default: ;
        endcase
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_pkg::*;
#(
    parameter int CTRL_W     = 32,
    parameter int N_UNITS    = 4,
    parameter int DOZE_DELAY = 4,
    parameter int DPM_BIT    = 11,
    parameter int DOZE_BIT   = 8,
    parameter int NAP_BIT    = 9,
    parameter int SLEEP_BIT  = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CTRL_W-1:0]  pm_ctrl,
    input  logic [N_UNITS-1:0] unit_req,
    input  logic               quiesce_ack,
    input  logic               snoop_hit,
    input  logic               copyback_done,
    output logic [N_UNITS-1:0] unit_clk_en,
    output logic               cache_clk_en,
    output logic               snoop_clk_en,
    output logic               timer_clk_en,
    output logic               copyback_req,
    output logic               quiesce_req,
    output logic [2:0]         mode
);
    ctrl_dec_t  dec;
    seq_state_e state;
    logic       doze_expired;
    gate_t      gate;
    pwr_mode_e  mode_e;

    pwr_ctrl_decode #(
        .CTRL_W(CTRL_W), .DPM_BIT(DPM_BIT), .DOZE_BIT(DOZE_BIT),
        .NAP_BIT(NAP_BIT), .SLEEP_BIT(SLEEP_BIT)
    ) u_decode (
        .ctrl (pm_ctrl),
        .dec  (dec)
    );

    pwr_doze_delay #(.DLY(DOZE_DELAY)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .count_en (state == ST_DOZE_WAIT),
        .expired  (doze_expired)
    );

    pwr_seq_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .dec          (dec),
        .qack         (quiesce_ack),
        .snoop_hit    (snoop_hit),
        .cb_done      (copyback_done),
        .doze_expired (doze_expired),
        .state        (state)
    );

    pwr_gate_decode #(.N_UNITS(N_UNITS)) u_gate (
        .state    (state),
        .dpm      (dec.dpm),
        .unit_req (unit_req),
        .unit_en  (unit_clk_en),
        .gate     (gate),
        .mode     (mode_e)
    );

    assign cache_clk_en = gate.cache;
    assign snoop_clk_en = gate.snoop;
    assign timer_clk_en = gate.timer;
    assign copyback_req = gate.cb_req;
    assign quiesce_req  = gate.qreq;
    assign mode         = mode_e;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk
    import pwr_pkg::*;
#(
    parameter int N_UNITS = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [N_UNITS-1:0] unit_req,
    input logic               quiesce_ack,
    input logic [N_UNITS-1:0] unit_clk_en,
    input logic               cache_clk_en,
    input logic               snoop_clk_en,
    input logic               timer_clk_en,
    input logic               copyback_req,
    input logic               quiesce_req,
    input logic [2:0]         mode
);
    logic low_pwr;
    assign low_pwr = (mode == MODE_NAP) || (mode == MODE_SLEEP);

    p_reset_full_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode == MODE_FULL || mode == MODE_DPM) && !quiesce_req);

    p_full_units_r1: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_FULL |-> (&unit_clk_en) && cache_clk_en && snoop_clk_en && timer_clk_en);

    p_dpm_follow_r2: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_DPM |-> unit_clk_en == unit_req);

    p_doze_gates_r4: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_DOZE |-> unit_clk_en == '0 && !cache_clk_en && snoop_clk_en && timer_clk_en);

    p_cb_in_snoop_r5: assert property (@(posedge clk) disable iff (rst)
        copyback_req |-> cache_clk_en && mode == MODE_SNOOP);

    p_entry_needs_ack_r6: assert property (@(posedge clk) disable iff (rst)
        low_pwr && !($past(mode) == MODE_NAP || $past(mode) == MODE_SLEEP) |-> $past(quiesce_ack));

    p_wake_on_drop_r7: assert property (@(posedge clk) disable iff (rst)
        low_pwr && !quiesce_ack |=> (mode == MODE_FULL || mode == MODE_DPM) && !quiesce_req);

    p_qreq_held_r9: assert property (@(posedge clk) disable iff (rst)
        low_pwr |-> quiesce_req);

    p_sleep_timer_r10: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_SLEEP |-> !timer_clk_en && !snoop_clk_en && unit_clk_en == '0);

    p_nap_timer_r10: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_NAP |-> timer_clk_en && !cache_clk_en);

    p_code_range_r11: assert property (@(posedge clk) disable iff (rst)
        mode <= 3'd5);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.N_UNITS(N_UNITS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .unit_req     (unit_req),
    .quiesce_ack  (quiesce_ack),
    .unit_clk_en  (unit_clk_en),
    .cache_clk_en (cache_clk_en),
    .snoop_clk_en (snoop_clk_en),
    .timer_clk_en (timer_clk_en),
    .copyback_req (copyback_req),
    .quiesce_req  (quiesce_req),
    .mode         (mode)
);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;
    localparam int NU = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          b_dpm = 0, b_doze = 0, b_nap = 0, b_sleep = 0;
    logic [31:0]   pm_ctrl;
    logic [NU-1:0] unit_req = '0;
    logic          quiesce_ack = 0, snoop_hit = 0, copyback_done = 0;
    logic [NU-1:0] unit_clk_en;
    logic          cache_clk_en, snoop_clk_en, timer_clk_en, copyback_req, quiesce_req;
    logic [2:0]    mode;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign pm_ctrl = (32'(b_dpm) << 11) | (32'(b_sleep) << 10) | (32'(b_nap) << 9) | (32'(b_doze) << 8);

    pwr_mode_ctrl u_dut (
        .clk(clk), .rst(rst), .pm_ctrl(pm_ctrl), .unit_req(unit_req),
        .quiesce_ack(quiesce_ack), .snoop_hit(snoop_hit), .copyback_done(copyback_done),
        .unit_clk_en(unit_clk_en), .cache_clk_en(cache_clk_en), .snoop_clk_en(snoop_clk_en),
        .timer_clk_en(timer_clk_en), .copyback_req(copyback_req),
        .quiesce_req(quiesce_req), .mode(mode)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: phase numbers and a countdown.
    localparam int P_RUN = 0, P_DW = 1, P_QW = 2, P_NAP = 3, P_SLP = 4,
                   P_DOZE = 5, P_SA = 6, P_SB = 7, P_SC = 8;
    int m_ph;
    int m_left;

    function automatic int wanted();
        if (b_sleep) return 3;
        if (b_nap)   return 2;
        if (b_doze)  return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ph   <= P_RUN;
            m_left <= 3;
        end else begin
            case (m_ph)
                P_RUN:  if (wanted() >= 2) m_ph <= P_QW;
                        else if (wanted() == 1) begin m_ph <= P_DW; m_left <= 3; end
                P_DW:   if (wanted() != 1) m_ph <= P_RUN;
                        else if (m_left == 0) m_ph <= P_DOZE;
                        else m_left <= m_left - 1;
                P_QW:   if (wanted() < 2) m_ph <= P_RUN;
                        else if (quiesce_ack) m_ph <= (wanted() == 3) ? P_SLP : P_NAP;
                P_NAP, P_SLP: if (!quiesce_ack) m_ph <= P_RUN;
                P_DOZE: if (snoop_hit) m_ph <= P_SA;
                        else if (wanted() != 1) m_ph <= P_RUN;
                P_SA:   m_ph <= P_SB;
                P_SB:   if (copyback_done) m_ph <= P_SC;
                P_SC:   m_ph <= P_DOZE;
                default: m_ph <= P_RUN;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            int e_mode, e_units;
            bit e_cache, e_snoop, e_timer, e_cb, e_q;
            string t;
            e_units = 0; e_cache = 0; e_snoop = 1; e_timer = 1; e_cb = 0; e_q = 0;
            case (m_ph)
                P_RUN, P_DW, P_QW: begin
                    e_mode  = b_dpm ? 1 : 0;
                    e_units = b_dpm ? int'(unit_req) : (1 << NU) - 1;
                    e_cache = 1;
                    e_q     = (m_ph == P_QW);
                    t       = (m_ph == P_QW) ? "R9" : (b_dpm ? "R2" : "R1");
                end
                P_NAP:  begin e_mode = 3; e_snoop = 0; e_q = 1; t = "R10"; end
                P_SLP:  begin e_mode = 4; e_snoop = 0; e_timer = 0; e_q = 1; t = "R10"; end
                P_DOZE: begin e_mode = 2; t = "R4"; end
                P_SA:   begin e_mode = 5; e_cache = 1; t = "R5"; end
                P_SB:   begin e_mode = 5; e_cache = 1; e_cb = 1; t = "R5"; end
                default: begin e_mode = 5; t = "R5"; end
            endcase
            chk(int'(mode) == e_mode, "R11", "mode", mode, e_mode);
            chk(int'(unit_clk_en) == e_units, t, "unit_clk_en", unit_clk_en, e_units);
            chk(cache_clk_en == e_cache, t, "cache_clk_en", cache_clk_en, e_cache);
            chk(snoop_clk_en == e_snoop, t, "snoop_clk_en", snoop_clk_en, e_snoop);
            chk(timer_clk_en == e_timer, t, "timer_clk_en", timer_clk_en, e_timer);
            chk(copyback_req == e_cb, "R5", "copyback_req", copyback_req, e_cb);
            chk(quiesce_req == e_q, "R9", "quiesce_req", quiesce_req, e_q);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        @(negedge clk);
        chk(mode == 3'd0 && unit_clk_en == '1, "R1", "reset mode/units", {mode, unit_clk_en}, {3'd0, 4'hf});
        tick(1);
        for (int i = 0; i < 6; i++) begin unit_req = NU'(i * 5 + 3); tick(1); end
        // R2 dynamic management
        b_dpm = 1;
        for (int i = 0; i < 10; i++) begin
            unit_req = NU'(i * 7 + 1);
            tick(1);
            @(negedge clk);
            chk(mode == 3'd1 && unit_clk_en == unit_req, "R2", "dpm gating", unit_clk_en, unit_req);
        end
        b_dpm = 0;
        // R3 doze latency
        b_doze = 1;
        tick(4);
        @(negedge clk);
        chk(mode != 3'd2, "R3", "doze too early", mode, 0);
        tick(1);
        @(negedge clk);
        chk(mode == 3'd2, "R3", "doze after delay", mode, 2);
        chk(unit_clk_en == '0 && snoop_clk_en && timer_clk_en && !cache_clk_en, "R4", "doze gates",
            {unit_clk_en, cache_clk_en, snoop_clk_en, timer_clk_en}, 3);
        // R5 snoop service that keeps doze
        snoop_hit = 1; tick(1); snoop_hit = 0;
        @(negedge clk);
        chk(mode == 3'd5 && cache_clk_en && !copyback_req, "R5", "snoop open", {mode, cache_clk_en}, {3'd5, 1'b1});
        tick(1);
        @(negedge clk);
        chk(copyback_req && cache_clk_en, "R5", "copyback request", copyback_req, 1);
        tick(2);
        copyback_done = 1; tick(1); copyback_done = 0;
        @(negedge clk);
        chk(mode == 3'd5 && !cache_clk_en, "R5", "snoop close", {mode, cache_clk_en}, {3'd5, 1'b0});
        tick(1);
        @(negedge clk);
        chk(mode == 3'd2, "R5", "back to doze", mode, 2);
        // R12 plain exit
        b_doze = 0; tick(1);
        @(negedge clk);
        chk(mode == 3'd0, "R12", "doze exit", mode, 0);
        // R12 exit during snoop service
        b_dpm = 1; b_doze = 1; tick(7);
        snoop_hit = 1; tick(1); snoop_hit = 0; b_doze = 0;
        @(negedge clk);
        chk(mode == 3'd5, "R12", "snoop continues", mode, 5);
        tick(2);
        @(negedge clk);
        chk(mode == 3'd5 && copyback_req, "R12", "still flushing", mode, 5);
        copyback_done = 1; tick(1); copyback_done = 0;
        tick(1);
        @(negedge clk);
        chk(mode == 3'd2, "R12", "doze once more", mode, 2);
        tick(1);
        @(negedge clk);
        chk(mode == 3'd1, "R12", "exit after service", mode, 1);
        b_dpm = 0;
        // R6 / R10 / R7 nap
        b_nap = 1; tick(1);
        @(negedge clk);
        chk(quiesce_req && mode == 3'd0, "R6", "waiting for ack", {quiesce_req, mode}, {1'b1, 3'd0});
        tick(3);
        @(negedge clk);
        chk(mode != 3'd3, "R6", "no nap without ack", mode, 0);
        quiesce_ack = 1; tick(1);
        @(negedge clk);
        chk(mode == 3'd3 && timer_clk_en, "R10", "nap timer on", {mode, timer_clk_en}, {3'd3, 1'b1});
        tick(3);
        quiesce_ack = 0; b_nap = 0; tick(1);
        @(negedge clk);
        chk(mode == 3'd0 && !quiesce_req, "R7", "wake from nap", {mode, quiesce_req}, 0);
        // R8 priority, R10 sleep
        b_doze = 1; b_nap = 1; b_sleep = 1; tick(1);
        quiesce_ack = 1; tick(1);
        @(negedge clk);
        chk(mode == 3'd4, "R8", "sleep wins", mode, 4);
        chk(!timer_clk_en, "R10", "sleep timer off", timer_clk_en, 0);
        tick(2);
        quiesce_ack = 0; b_doze = 0; b_nap = 0; b_sleep = 0; b_dpm = 1; tick(1);
        @(negedge clk);
        chk(mode == 3'd1 && !quiesce_req, "R7", "wake from sleep", {mode, quiesce_req}, {3'd1, 1'b0});
        // R8 nap over doze
        b_doze = 1; b_nap = 1; tick(1);
        @(negedge clk);
        chk(quiesce_req, "R8", "nap beats doze", quiesce_req, 1);
        // R9 withdrawn request
        b_nap = 0; b_doze = 0; tick(1);
        @(negedge clk);
        chk(!quiesce_req && mode == 3'd1, "R9", "request withdrawn", quiesce_req, 0);
        // randomized phase
        for (int i = 0; i < 600; i++) begin
            if (i % 16 == 0) begin
                int r;
                r = int'($urandom % 8);
                b_dpm = $urandom % 2; b_doze = r[0]; b_nap = r[1] && (i % 48 == 0); b_sleep = r[2] && (i % 32 == 0);
            end
            unit_req      = NU'($urandom);
            quiesce_ack   = ($urandom % 4) != 0;
            snoop_hit     = ($urandom % 6) == 0;
            copyback_done = ($urandom % 3) == 0;
            tick(1);
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule